// File: doc/BRIEF.md
# Card I/O Character Transmitter with Guard-Time Spacing

This block is the sending half of a reader's single-wire link to a contact chip card. It takes one byte at a time over a valid/ready handshake and shifts it out on a single open-high line. Each character is a low start bit, eight data bits and an even parity bit. Every bit lasts one elementary time unit (ETU), a count of system clocks set by the caller.

The block can send in two conventions. In direct convention the least significant bit goes first and a logic one is a high level. In inverse convention the most significant bit goes first and every level, parity included, is inverted. After the parity bit the line returns high. The next start edge is held back until the guard interval has passed since the previous start edge. That interval is twelve ETUs plus an extra count N. The value N = 255 is special: it selects eleven ETUs under the block-oriented protocol and twelve under the character-oriented one.

The ETU length, N, protocol select and convention are sampled when a byte is accepted and stay fixed until that character's guard interval ends. Reception, error-signal retransmission and the choice of ETU length all belong to neighbouring logic.

Top module: `card_char_tx`

## Requirements
- R1: After reset, with no byte pending, `io_out` is high and `tx_ready` is high.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in the cycle after acceptance.
- R3: The start bit is a low level that begins in the cycle after acceptance and lasts one ETU.
- R4: With `conv_inverse` = 0, the eight data bits follow the start bit least significant first, with 1 sent as high. They are followed by a parity bit whose level equals the XOR of the data bits (even parity).
- R5: With `conv_inverse` = 1, the data bits follow the start bit most significant first, with every level inverted (1 sent as low). The parity bit is sent as the inverse of the XOR of the data bits.
- R6: For `extra_gt` N in 0..254, the guard interval is (12 + N) ETUs, counted from the start edge of one character to the earliest start edge of the next.
- R7: For N = 255 with `proto_t1` = 0, the guard interval is 12 ETUs.
- R8: For N = 255 with `proto_t1` = 1, the guard interval is 11 ETUs.
- R9: From the end of the parity bit to the end of the guard interval, and whenever the block is idle, `io_out` is high.
- R10: `etu_clks`, `extra_gt`, `proto_t1` and `conv_inverse` are sampled at acceptance. Changing them while a character is in flight has no effect on that character's bits or guard interval.
- R11: `tx_ready` first rises in the last clock of the guard interval. A byte held valid early is therefore accepted so that its start edge falls exactly one guard interval after the previous start edge, and never sooner.
- R12: An `etu_clks` value of 0 is treated as one clock per ETU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte on this edge |
| etu_clks | input | ETU_W | Clocks per ETU (0 acts as 1) |
| extra_gt | input | 8 | Extra guard count N |
| proto_t1 | input | 1 | 1 selects block-oriented protocol, 0 character-oriented |
| conv_inverse | input | 1 | 1 selects inverse convention |
| io_out | output | 1 | Serial line to the card, high when released |

## Verification
Two events can fall in the same clock: the last clock of one character's guard interval and the acceptance of the next byte, which loads a fresh frame and fresh counters. The bench provokes this by raising `tx_valid` with a second byte straight after the first is accepted and holding it there. It then measures the clock count between the two falling start edges on `io_out`, which must equal the guard length exactly. It also confirms that `tx_ready` never rose before the final guard clock.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
   // start + 8 data + parity
   localparam int unsigned FRAME_LEN = 10;
   localparam int unsigned FI_W      = $clog2(FRAME_LEN);
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned NX_W      = 8;
   // guard length in ETUs fits 12 + 254 = 266
   localparam int unsigned GT_W      = 9;
   localparam int unsigned BASE_GT   = 12;
   localparam int unsigned T1_SAT_GT = 11;
   localparam logic [NX_W-1:0] NX_SAT = '1;

   typedef logic [FRAME_LEN-1:0] line_frame_t;
   typedef logic [GT_W-1:0]      gt_len_t;
endpackage

// File: rtl/ctx_guard_calc.sv
module ctx_guard_calc
   import ctx_pkg::*;
(
   input  logic [NX_W-1:0] extra_n,
   input  logic            t1_sel,
   output gt_len_t         guard_etus
);
   gt_len_t sat_len;

   always_comb begin
      sat_len = t1_sel ? GT_W'(T1_SAT_GT) : GT_W'(BASE_GT);
      if (extra_n == NX_SAT) guard_etus = sat_len;
      else                   guard_etus = GT_W'(BASE_GT) + GT_W'(extra_n);
   end
endmodule

// File: rtl/ctx_frame_enc.sv
module ctx_frame_enc
   import ctx_pkg::*;
(
   input  logic [DATA_W-1:0] byte_in,
   input  logic              inverse,
   output line_frame_t       frame
);
   logic par_even;
   assign par_even = ^byte_in;

   // slot 0: start bit, always low
   assign frame[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_slot
         assign frame[gi+1] = inverse ? ~byte_in[DATA_W-1-gi] : byte_in[gi];
      end
   endgenerate

   assign frame[FRAME_LEN-1] = inverse ? ~par_even : par_even;
endmodule

// File: rtl/ctx_etu_seq.sv
module ctx_etu_seq
   import ctx_pkg::*;
#(
   parameter int unsigned ETU_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ETU_W-1:0] etu_len,
   input  gt_len_t          guard_len,
   output logic             busy,
   output gt_len_t          etu_idx,
   output logic             last_tick
);
   logic [ETU_W-1:0] clk_cnt_q;
   logic [ETU_W-1:0] len_q;
   gt_len_t          idx_q;
   gt_len_t          gt_q;
   logic             busy_q;
   logic             etu_end;

   assign etu_end   = busy_q && (clk_cnt_q == len_q - ETU_W'(1));
   assign last_tick = etu_end && (idx_q == gt_q - GT_W'(1));
   assign busy      = busy_q;
   assign etu_idx   = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         clk_cnt_q <= '0;
         len_q     <= ETU_W'(1);
         idx_q     <= '0;
         gt_q      <= GT_W'(BASE_GT);
      end else if (load) begin
         busy_q    <= 1'b1;
         clk_cnt_q <= '0;
         len_q     <= etu_len;
         idx_q     <= '0;
         gt_q      <= guard_len;
      end else if (busy_q) begin
         if (etu_end) begin
            clk_cnt_q <= '0;
            if (last_tick) busy_q <= 1'b0;
            else           idx_q  <= idx_q + GT_W'(1);
         end else begin
            clk_cnt_q <= clk_cnt_q + ETU_W'(1);
         end
      end
   end
endmodule

// File: rtl/card_char_tx.sv
module card_char_tx
   import ctx_pkg::*;
#(
   parameter int unsigned ETU_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic [ETU_W-1:0] etu_clks,
   input  logic [7:0]       extra_gt,
   input  logic             proto_t1,
   input  logic             conv_inverse,
   output logic             io_out
);
   generate
      if (ETU_W < 2 || ETU_W > 24) begin : g_bad_etu_w
         $error("card_char_tx: ETU_W must lie in 2..24");
      end
      if (DATA_W != 8 || NX_W != 8) begin : g_bad_pkg
         $error("card_char_tx: package widths must stay at 8");
      end
   endgenerate

   logic             busy;
   logic             last_tick;
   logic             accept;
   gt_len_t          etu_idx;
   gt_len_t          guard_now;
   line_frame_t      frame_now;
   line_frame_t      frame_q;
   logic [ETU_W-1:0] etu_eff;

   assign tx_ready = !busy || last_tick;
   assign accept   = tx_valid && tx_ready;
   assign etu_eff  = (etu_clks == '0) ? ETU_W'(1) : etu_clks;

   ctx_guard_calc u_guard (
      .extra_n    (extra_gt),
      .t1_sel     (proto_t1),
      .guard_etus (guard_now)
   );

   ctx_frame_enc u_enc (
      .byte_in (tx_data),
      .inverse (conv_inverse),
      .frame   (frame_now)
   );

   ctx_etu_seq #(.ETU_W(ETU_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .etu_len   (etu_eff),
      .guard_len (guard_now),
      .busy      (busy),
      .etu_idx   (etu_idx),
      .last_tick (last_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      frame_q <= '1;
      else if (accept) frame_q <= frame_now;
   end

   always_comb begin
      if (busy && etu_idx < GT_W'(FRAME_LEN)) io_out = frame_q[etu_idx[FI_W-1:0]];
      else                                    io_out = 1'b1;
   end
endmodule

// File: rtl/card_char_tx_chk.sv
module card_char_tx_chk #(
   parameter int unsigned ETU_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [ETU_W-1:0] etu_clks,
   input logic [7:0]       extra_gt,
   input logic             proto_t1,
   input logic             io_out
);
   logic        acc;
   logic        seen_q;
   logic [31:0] since_q;
   logic [31:0] req_q;
   logic [31:0] gt_w;
   logic [31:0] e_w;

   assign acc  = tx_valid && tx_ready;
   assign e_w  = (etu_clks == '0) ? 32'd1 : 32'(etu_clks);
   assign gt_w = (extra_gt == 8'd255) ? (proto_t1 ? 32'd11 : 32'd12)
                                      : (32'd12 + 32'(extra_gt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         since_q <= '0;
         req_q   <= '0;
      end else if (acc) begin
         seen_q  <= 1'b1;
         since_q <= 32'd1;
         req_q   <= gt_w * e_w;
      end else if (since_q != '1) begin
         since_q <= since_q + 32'd1;
      end
   end

   // R2: acceptance closes the handshake for the next cycle
   p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !tx_ready);

   // R3: start bit appears right after acceptance
   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !io_out);

   // R9: line released whenever a byte may be taken
   p_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> io_out);

   // R6 R7 R8 R11: start edges never closer than the guard interval
   p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && seen_q) |-> (since_q >= req_q));

   // R1: ready stays high while idle and nothing offered
   p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_valid && since_q >= req_q) |=> tx_ready);
endmodule

bind card_char_tx card_char_tx_chk #(.ETU_W(ETU_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .etu_clks (etu_clks),
   .extra_gt (extra_gt),
   .proto_t1 (proto_t1),
   .io_out   (io_out)
);

// File: tb/card_char_tx_tb_top.sv
`timescale 1ns/1ps
module card_char_tx_tb_top;
   localparam int ETU_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       tx_data = '0;
   logic             tx_valid = 1'b0;
   logic             tx_ready;
   logic [ETU_W-1:0] etu_clks = 16'd4;
   logic [7:0]       extra_gt = '0;
   logic             proto_t1 = 1'b0;
   logic             conv_inverse = 1'b0;
   logic             io_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   card_char_tx #(.ETU_W(ETU_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .etu_clks(etu_clks), .extra_gt(extra_gt),
      .proto_t1(proto_t1), .conv_inverse(conv_inverse), .io_out(io_out)
   );

   // {data[33:26], inverse[25], t1[24], N[23:16], etu[15:0]}
   localparam logic [33:0] VEC [8] = '{
      {8'hA5, 1'b0, 1'b0, 8'd0,   16'd4},
      {8'h3C, 1'b1, 1'b0, 8'd0,   16'd5},
      {8'h01, 1'b0, 1'b0, 8'd3,   16'd3},
      {8'h80, 1'b1, 1'b1, 8'd2,   16'd4},
      {8'hFF, 1'b0, 1'b0, 8'd255, 16'd2},
      {8'h00, 1'b1, 1'b1, 8'd255, 16'd3},
      {8'h96, 1'b0, 1'b1, 8'd254, 16'd1},
      {8'h5A, 1'b0, 1'b1, 8'd255, 16'd2}
   };

   function automatic logic [9:0] exp_line(input logic [7:0] d, input logic inv);
      logic [9:0] f;
      f[0] = 1'b0;
      for (int i = 1; i <= 8; i++) f[i] = inv ? ~d[8-i] : d[i-1];
      f[9] = inv ? ~(^d) : (^d);
      return f;
   endfunction

   function automatic int exp_guard(input logic [7:0] n, input logic t1);
      if (n == 8'd255) return t1 ? 11 : 12;
      return 12 + int'(n);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sends one character, checks it, returns number of failed checks
   task automatic run_char(input logic [7:0] d, input logic inv, input logic t1,
                           input logic [7:0] n, input int etu_drive, input int etu_after,
                           input int e, output int errs);
      logic [9:0] obs;
      logic [9:0] expv;
      int g;
      int first_rdy;
      bit low_seen;
      int f0;
      errs = 0;
      f0 = failures;
      g = exp_guard(n, t1);
      expv = exp_line(d, inv);
      obs = '0;
      first_rdy = -1;
      low_seen = 1'b0;
      @(negedge clk);
      tx_data = d; conv_inverse = inv; proto_t1 = t1; extra_gt = n;
      etu_clks = 16'(etu_drive); tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      etu_clks = 16'(etu_after);
      extra_gt = ~n; proto_t1 = ~t1; conv_inverse = ~inv; tx_data = ~d;
      // R2: ready low in the cycle after acceptance; R3: start bit low
      chk(tx_ready == 1'b0, "R2 ready after accept", int'(tx_ready), 0);
      chk(io_out == 1'b0, "R3 start bit", int'(io_out), 0);
      for (int c = 0; c < 5000; c++) begin
         if (c > 0) @(negedge clk);
         if ((c % e) == (e / 2) && (c / e) < 10) obs[c / e] = io_out;
         if (c >= 10 * e && !io_out) low_seen = 1'b1;
         if (tx_ready) begin
            first_rdy = c;
            break;
         end
      end
      chk(obs == expv, inv ? "R5 inverse frame" : "R4 direct frame", int'(obs), int'(expv));
      chk(!low_seen, "R9 line high in guard", int'(low_seen), 0);
      if (n == 8'd255)
         chk(first_rdy == g * e - 1, t1 ? "R8 guard N255 T1" : "R7 guard N255 T0",
             first_rdy, g * e - 1);
      else
         chk(first_rdy == g * e - 1, "R6 guard 12+N", first_rdy, g * e - 1);
      errs = failures - f0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int errs;
      int fall_c;
      bit early;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(io_out == 1'b1, "R1 line during reset", int'(io_out), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(io_out == 1'b1 && tx_ready == 1'b1, "R1 idle after reset",
          int'({io_out, tx_ready}), 3);

      for (int v = 0; v < 8; v++) begin
         logic [33:0] w;
         w = VEC[v];
         run_char(w[33:26], w[25], w[24], w[23:16], int'(w[15:0]), int'(w[15:0]),
                  int'(w[15:0]), errs);
         repeat (2) @(negedge clk);
      end

      // R10: inputs changed mid-character (done inside run_char) with a
      // different ETU value after acceptance
      run_char(8'hC3, 1'b0, 1'b0, 8'd1, 4, 9, 4, errs);
      chk(errs == 0, "R10 settings latched at accept", errs, 0);
      repeat (2) @(negedge clk);

      // R12: ETU of zero behaves as one clock
      run_char(8'h6E, 1'b1, 1'b0, 8'd0, 0, 0, 1, errs);
      chk(errs == 0, "R12 zero ETU as one", errs, 0);
      repeat (2) @(negedge clk);

      // R11: second byte held valid from the cycle after the first accept
      early = 1'b0;
      fall_c = -1;
      @(negedge clk);
      tx_data = 8'h11; conv_inverse = 1'b0; proto_t1 = 1'b0; extra_gt = 8'd2;
      etu_clks = 16'd3; tx_valid = 1'b1;
      @(negedge clk);
      tx_data = 8'h22;
      for (int c = 0; c < 5000; c++) begin
         if (c > 0) @(negedge clk);
         if (tx_ready && c < 14 * 3 - 1) early = 1'b1;
         if (c >= 30 && !io_out) begin
            fall_c = c;
            tx_valid = 1'b0;
            break;
         end
      end
      chk(fall_c == 14 * 3, "R11 back-to-back spacing", fall_c, 14 * 3);
      chk(!early, "R11 ready held off", int'(early), 0);
      for (int c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (tx_ready) break;
      end
      repeat (2) @(negedge clk);
      chk(io_out == 1'b1 && tx_ready == 1'b1, "R1 idle after traffic",
          int'({io_out, tx_ready}), 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule